// File: doc/BRIEF.md
# DMA Channel Interrupt Register Unit

This block keeps the interrupt state of a single DMA channel behind a plain 32-bit register bus. It has three sources of events: one-cycle pulses from the channel datapath, two descriptor-completion strobes (source side and destination side), and bus accesses to addresses it does not decode. Each source sets a bit in a 12-bit sticky status register. Software clears status bits by writing ones to them.

Masking is controlled through two write-only ports. One clears mask bits and the other sets them, and the mask register itself is read-only. A level interrupt output is asserted while any status bit is set whose mask bit is clear.

Two 8-bit accounting counters track how many descriptors have completed on each side. Reading a counter returns its value and clears it. If a counter wraps, a dedicated error status bit is raised.

The bus is a single-cycle access: `reg_sel` qualifies the access and `reg_wr` chooses write or read. Read data is combinational from the current state. Every side effect (clearing, mask update, clear-on-read, invalid-access flag) takes place at the next rising clock edge.

Register byte offsets:
- 0x00: status
- 0x04: mask
- 0x08: unmask port
- 0x0C: mask-set port
- 0x10: source counter
- 0x14: destination counter

Top module: `dma_irq_regs`

## Requirements
- R1: Status bits, from bit 0 upward, are: invalid access, source descriptor done, destination descriptor done, byte count overflow, source accounting error, destination accounting error, source descriptor read error, destination descriptor read error, data read error, data write error, transfer done, transfer paused. A pulse on `evt_set[k]` sets status bit k on the next edge. Status resets to 0.
- R2: Writing offset 0x00 clears every status bit that is written as 1. Bits 31:12 of the written value have no effect, and status reads with bits 31:12 at zero.
- R3: When an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R4: The mask (offset 0x04) resets to 0xFFF. A write to offset 0x04 changes nothing.
- R5: Writing offset 0x08 clears the mask bits that are written as 1. Writing offset 0x0C sets the mask bits that are written as 1. Both offsets read as 0.
- R6: `irq` is high exactly when some status bit is 1 and its mask bit is 0. It reflects the registers after each edge.
- R7: A `src_dscr_done` pulse increments the source counter (offset 0x10) and sets status bit 1. A `dst_dscr_done` pulse increments the destination counter (offset 0x14) and sets status bit 2.
- R8: An increment that takes a counter from 255 to 0 sets status bit 4 for the source counter, or status bit 5 for the destination counter.
- R9: Reading a counter returns its current value and leaves it at 0.
- R10: If a counter is read in the same cycle that it is incremented, the read returns the old value and the counter then holds 1, with no accounting error.
- R11: A read or write at any word offset above 0x14 sets status bit 0, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (8) | Byte address; bits 1:0 ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| evt_set | input | STAT_W (12) | Datapath event pulses, one per status bit |
| src_dscr_done | input | 1 | Source descriptor completed |
| dst_dscr_done | input | 1 | Destination descriptor completed |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume:
- `reg_sel` stays asserted for exactly one edge per access.
- An event pulse is observed on one edge only.
- Only one register offset is accessed in a given cycle.

Because of this, an unmask write and a mask-set write never coincide. The stimulus drives every input at the falling edge and keeps every access to a single-cycle strobe. Overlaps are produced on purpose only where a requirement defines the outcome: an event against a clear, and a counter read against an increment.

// File: rtl/dma_irq_pkg.sv
// Package: shared constants of the DMA channel interrupt register unit.
// Assumes a 32-bit register bus with word-aligned offsets.
package dma_irq_pkg;
    localparam int BUS_W        = 32;
    // status bit positions (decoded by the counter and decode logic)
    localparam int BIT_BADACC   = 0;
    localparam int BIT_SRC_DONE = 1;
    localparam int BIT_DST_DONE = 2;
    localparam int BIT_SRC_ERR  = 4;
    localparam int BIT_DST_ERR  = 5;
    // word indices of the register map
    localparam int IDX_STATUS   = 0;
    localparam int IDX_MASK     = 1;
    localparam int IDX_UNMASK   = 2;
    localparam int IDX_SETMASK  = 3;
    localparam int IDX_SRC_CNT  = 4;
    localparam int IDX_DST_CNT  = 5;
    localparam int IDX_LAST     = 5;
endpackage

// File: rtl/irq_status_reg.sv
// Module: sticky status register. Write-one-to-clear, and a set wins
// over a clear of the same bit. Assumes set and clear are one-cycle strobes.
module irq_status_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] st_q;

    // Update the status: clear first, then apply the sets so that sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_i) | set_i;
    end

    assign status_o = st_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i))); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((status_o & $past(clr_i & ~set_i)) == '0)); // R2
endmodule

// File: rtl/irq_mask_reg.sv
// Module: interrupt mask. Reset is all ones (every source masked). The mask
// changes only through the unmask port and the mask-set port.
// Assumes the two ports are never written in the same cycle.
module irq_mask_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         unmask_wr_i,
    input  logic         setmask_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q;

    // Clear or set the mask bits selected by the write data.
    always_ff @(posedge clk) begin
        if (!rst_n)            mask_q <= '1;
        else if (unmask_wr_i)  mask_q <= mask_q & ~wdata_i;
        else if (setmask_wr_i) mask_q <= mask_q | wdata_i;
    end

    assign mask_o = mask_q;

    AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_wr_i |=> ((mask_o & $past(wdata_i)) == '0)); // R5
    AST_SETMASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (setmask_wr_i && !unmask_wr_i) |=> ((mask_o & $past(wdata_i)) == $past(wdata_i))); // R5
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!unmask_wr_i && !setmask_wr_i) |=> $stable(mask_o)); // R4
endmodule

// File: rtl/acct_counter.sv
// Module: descriptor-completion counter. It clears on a read, and an
// increment in the same cycle leaves it at 1. wrap_o flags the step from
// the maximum value to zero, which can happen only when no read occurs.
module acct_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          rd_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);
    localparam logic [CW-1:0] CNT_MAX = '1;
    logic [CW-1:0] cnt_q;

    // Count completions; a read restarts the count from the same-cycle increment.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (rd_i)  cnt_q <= CW'(inc_i);
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = inc_i && !rd_i && (cnt_q == CNT_MAX);

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> (cnt_o == CW'($past(inc_i)))); // R10
    AST_INC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !rd_i) |=> (cnt_o == CW'($past(cnt_o) + 1'b1))); // R7
endmodule

// File: rtl/dma_irq_regs.sv
// Module: DMA channel interrupt register unit (top). It decodes the
// register bus, routes events into the status register, drives the mask
// and the accounting counters, and forms the level interrupt.
// Assumes single-cycle accesses with combinational read data.
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int STAT_W = 12,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic [STAT_W-1:0] evt_set,
    input  logic              src_dscr_done,
    input  logic              dst_dscr_done,
    output logic              irq
);
    localparam int IDX_W   = ADDR_W - 2;
    localparam int N_ACCT  = 2;

    logic [IDX_W-1:0]  idx;
    logic              wr_acc, rd_acc, bad_acc;
    logic [STAT_W-1:0] status_q, mask_q, clr_vec, set_vec, wdata_s;
    logic [N_ACCT-1:0] acct_inc, acct_rd, acct_wrap;
    logic [CNT_W-1:0]  acct_cnt [N_ACCT];
    logic              unused_bits;

    assign idx         = reg_addr[ADDR_W-1:2];
    assign wr_acc      = reg_sel && reg_wr;
    assign rd_acc      = reg_sel && !reg_wr;
    assign bad_acc     = reg_sel && (idx > IDX_W'(IDX_LAST));
    assign wdata_s     = reg_wdata[STAT_W-1:0];
    assign unused_bits = ^{reg_addr[1:0], reg_wdata[BUS_W-1:STAT_W]};

    // Build the clear vector from a write to the status offset.
    always_comb begin
        clr_vec = '0;
        if (wr_acc && idx == IDX_W'(IDX_STATUS)) clr_vec = wdata_s;
    end

    // Merge datapath events, descriptor completions, wraps and bad accesses.
    always_comb begin
        set_vec               = evt_set;
        set_vec[BIT_BADACC]   = set_vec[BIT_BADACC]   | bad_acc;
        set_vec[BIT_SRC_DONE] = set_vec[BIT_SRC_DONE] | src_dscr_done;
        set_vec[BIT_DST_DONE] = set_vec[BIT_DST_DONE] | dst_dscr_done;
        set_vec[BIT_SRC_ERR]  = set_vec[BIT_SRC_ERR]  | acct_wrap[0];
        set_vec[BIT_DST_ERR]  = set_vec[BIT_DST_ERR]  | acct_wrap[1];
    end

    irq_status_reg #(.W(STAT_W)) u_status (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_vec), .set_i(set_vec), .status_o(status_q)
    );

    irq_mask_reg #(.W(STAT_W)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .unmask_wr_i(wr_acc && idx == IDX_W'(IDX_UNMASK)),
        .setmask_wr_i(wr_acc && idx == IDX_W'(IDX_SETMASK)),
        .wdata_i(wdata_s), .mask_o(mask_q)
    );

    assign acct_inc = {dst_dscr_done, src_dscr_done};

    // One counter per side: index 0 = source, index 1 = destination.
    for (genvar g = 0; g < N_ACCT; g++) begin : g_acct
        localparam int RD_IDX  = (g == 0) ? IDX_SRC_CNT  : IDX_DST_CNT;
        localparam int ERR_BIT = (g == 0) ? BIT_SRC_ERR  : BIT_DST_ERR;
        localparam int DN_BIT  = (g == 0) ? BIT_SRC_DONE : BIT_DST_DONE;

        assign acct_rd[g] = rd_acc && idx == IDX_W'(RD_IDX);

        acct_counter #(.CW(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc_i(acct_inc[g]), .rd_i(acct_rd[g]),
            .cnt_o(acct_cnt[g]), .wrap_o(acct_wrap[g])
        );

        AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (acct_inc[g] && !acct_rd[g] && acct_cnt[g] == '1) |=> status_q[ERR_BIT]); // R8
        AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            acct_inc[g] |=> status_q[DN_BIT]); // R7
    end

    // Select read data; unused and write-only offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (rd_acc) begin
            case (idx)
                IDX_W'(IDX_STATUS):  reg_rdata = BUS_W'(status_q);
                IDX_W'(IDX_MASK):    reg_rdata = BUS_W'(mask_q);
                IDX_W'(IDX_SRC_CNT): reg_rdata = BUS_W'(acct_cnt[0]);
                IDX_W'(IDX_DST_CNT): reg_rdata = BUS_W'(acct_cnt[1]);
                default:             reg_rdata = '0;
            endcase
        end
    end

    // Level interrupt from the unmasked pending status.
    assign irq = |(status_q & ~mask_q);

    AST_BAD_ACCESS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |=> status_q[BIT_BADACC]); // R11
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_acc && !reg_wr) |-> (reg_rdata == '0)); // R11
endmodule

// File: tb/test_dma_irq_regs.sv
// Bench: a behavioural reference model updated at every rising edge and
// compared with the DUT at every falling edge (irq) and on every read.
module test_dma_irq_regs;
    localparam int CLK_P = 10;

    logic        clk = 0, rst_n = 0;
    logic        b_sel = 0, b_wr = 0;
    logic [7:0]  b_addr = 0;
    logic [31:0] b_wdata = 0, b_rdata;
    logic [11:0] b_ev = 0;
    logic        b_sd = 0, b_dd = 0, b_irq;

    int checks = 0, fails = 0;
    string cur_req = "R1";

    logic [11:0] m_st, m_mk;
    int m_cs, m_cd;

    always #(CLK_P/2) clk = ~clk;

    dma_irq_regs i_dma_irq_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(b_sel), .reg_wr(b_wr), .reg_addr(b_addr),
        .reg_wdata(b_wdata), .reg_rdata(b_rdata), .evt_set(b_ev),
        .src_dscr_done(b_sd), .dst_dscr_done(b_dd), .irq(b_irq)
    );

    // Reference model: one step per rising edge.
    always @(posedge clk) begin : model
        logic [11:0] nst, nmk;
        int idx;
        bit rd, rds, rdd;
        if (!rst_n) begin
            m_st = 0; m_mk = 12'hFFF; m_cs = 0; m_cd = 0;
        end else begin
            nst = m_st; nmk = m_mk;
            idx = int'(b_addr >> 2);
            rd  = b_sel && !b_wr;
            rds = rd && idx == 4;
            rdd = rd && idx == 5;
            if (b_sel && b_wr && idx == 0) nst = nst & ~b_wdata[11:0];
            if (b_sel && b_wr && idx == 2) nmk = nmk & ~b_wdata[11:0];
            if (b_sel && b_wr && idx == 3) nmk = nmk | b_wdata[11:0];
            if (b_sel && idx > 5) nst[0] = 1'b1;
            if (b_sd) begin
                if (!rds && m_cs == 255) nst[4] = 1'b1;
                nst[1] = 1'b1;
            end
            if (b_dd) begin
                if (!rdd && m_cd == 255) nst[5] = 1'b1;
                nst[2] = 1'b1;
            end
            m_cs = rds ? (b_sd ? 1 : 0) : (b_sd ? (m_cs + 1) % 256 : m_cs);
            m_cd = rdd ? (b_dd ? 1 : 0) : (b_dd ? (m_cd + 1) % 256 : m_cd);
            m_st = nst | b_ev;
            m_mk = nmk;
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (int'(a >> 2))
            0: return {20'h0, m_st};
            1: return {20'h0, m_mk};
            4: return 32'(m_cs);
            5: return 32'(m_cd);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle: check irq (R6), drive inputs, check read data if reading.
    task automatic step(input logic sel, input logic wr, input logic [7:0] a,
                        input logic [31:0] wd, input logic [11:0] ev,
                        input logic sd, input logic dd);
        @(negedge clk);
        if (rst_n) check("R6", 32'(b_irq), 32'(|(m_st & ~m_mk)));
        b_sel = sel; b_wr = wr; b_addr = a; b_wdata = wd; b_ev = ev; b_sd = sd; b_dd = dd;
        #1;
        if (rst_n && sel && !wr) check(cur_req, b_rdata, model_read(a));
    endtask

    task automatic idle();               step(0, 0, 0, 0, 0, 0, 0); endtask
    task automatic rd(input logic [7:0] a);             step(1, 0, a, 0, 0, 0, 0); endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d); step(1, 1, a, d, 0, 0, 0); endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) idle();
        rst_n = 1;
        idle();
        cur_req = "R4"; rd(8'h04); check("R4", b_rdata, 32'hFFF);
        cur_req = "R1"; rd(8'h00); check("R1", b_rdata, 32'h0);

        // R1: each event bit sets its own status bit
        for (int k = 0; k < 12; k++) begin
            step(0, 0, 0, 0, 12'(1 << k), 0, 0);
            rd(8'h00);
            wr(8'h00, 32'hFFF);
        end
        // R2: write-one-to-clear, upper bits ignored
        cur_req = "R2";
        step(0, 0, 0, 0, 12'hA5A, 0, 0);
        wr(8'h00, 32'hFFFF_F00A);
        rd(8'h00); check("R2", b_rdata, 32'hA50);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00); check("R2", b_rdata, 32'h0);
        // R3: event wins against a clear of the same bit
        cur_req = "R3";
        step(0, 0, 0, 0, 12'h400, 0, 0);
        step(1, 1, 8'h00, 32'h400, 12'h400, 0, 0);
        rd(8'h00); check("R3", b_rdata, 32'h400);
        wr(8'h00, 32'hFFF);
        // R4: mask offset is not writable
        cur_req = "R4";
        wr(8'h04, 32'h0);
        rd(8'h04); check("R4", b_rdata, 32'hFFF);
        // R5: unmask / mask-set ports, both read as zero
        cur_req = "R5";
        wr(8'h08, 32'h405);
        rd(8'h04); check("R5", b_rdata, 32'hBFA);
        rd(8'h08); check("R5", b_rdata, 32'h0);
        rd(8'h0C); check("R5", b_rdata, 32'h0);
        // R6: irq follows unmasked status (checked every cycle in step)
        cur_req = "R6";
        step(0, 0, 0, 0, 12'h002, 0, 0);
        idle(); check("R6", 32'(b_irq), 32'h0);
        step(0, 0, 0, 0, 12'h400, 0, 0);
        idle(); check("R6", 32'(b_irq), 32'h1);
        wr(8'h0C, 32'h400);
        idle(); check("R6", 32'(b_irq), 32'h0);
        wr(8'h08, 32'hFFF);
        idle(); check("R6", 32'(b_irq), 32'h1);
        wr(8'h00, 32'hFFF);
        // R7: counters and done bits
        cur_req = "R7";
        repeat (3) step(0, 0, 0, 0, 0, 1, 0);
        repeat (2) step(0, 0, 0, 0, 0, 0, 1);
        rd(8'h00); check("R7", b_rdata, 32'h006);
        rd(8'h10); check("R7", b_rdata, 32'd3);
        rd(8'h14); check("R7", b_rdata, 32'd2);
        // R9: read cleared them
        cur_req = "R9";
        rd(8'h10); check("R9", b_rdata, 32'd0);
        rd(8'h14); check("R9", b_rdata, 32'd0);
        wr(8'h00, 32'hFFF);
        // R8: wrap from 255 to 0 on both sides
        cur_req = "R8";
        repeat (255) step(0, 0, 0, 0, 0, 1, 1);
        rd(8'h00); check("R8", b_rdata, 32'h006);
        step(0, 0, 0, 0, 0, 1, 1);
        rd(8'h00); check("R8", b_rdata, 32'h036);
        rd(8'h10); check("R8", b_rdata, 32'd0);
        wr(8'h00, 32'hFFF);
        // R10: read concurrent with increment, also at 255
        cur_req = "R10";
        repeat (255) step(0, 0, 0, 0, 0, 1, 0);
        step(1, 0, 8'h10, 0, 0, 1, 0); check("R10", b_rdata, 32'd255);
        rd(8'h10); check("R10", b_rdata, 32'd1);
        rd(8'h00); check("R10", b_rdata, 32'h002);
        wr(8'h00, 32'hFFF);
        // R11: unimplemented offsets
        cur_req = "R11";
        rd(8'h18); check("R11", b_rdata, 32'h0);
        rd(8'h00); check("R11", b_rdata, 32'h001);
        wr(8'h00, 32'h1);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h00); check("R11", b_rdata, 32'h001);
        rd(8'h04); check("R11", b_rdata, 32'h000);
        repeat (2) idle();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule